// File: doc/BRIEF.md
# HDLC Receive Frame Checker

This block takes a serial HDLC line, one bit per clock when the bit-enable is high. It finds the flag that opens a frame, removes the zeros the transmitter inserted, and passes the frame content out as bytes, least significant bit first. Each frame ends with a closing flag, an abort sequence, a fast-abort command or a length overrun. At that point the block raises a one-cycle frame-end strobe and a six-bit status word for that frame.

The status word covers six conditions: the frame was too short for the selected check width, the frame check sequence failed, the length is not a whole number of octets, the frame was too long, the frame was aborted, and a downstream buffer reported lost data. The check width is 16 or 32 bits. The consumer must apply the don't-care rules in R4 and R5: some bits have no meaning when other bits are set.

Top module: `hdlc_rx_status`

## Requirements
- R1: Frame content leaves as bytes on `byte_out`, first received bit in bit 0. `byte_vld` pulses for one cycle for every 8 counted frame bits. The frame check sequence bits are included.
- R2: A flag is the pattern 01111110. The seven destuffed bits just before a closing flag or abort belong to the delimiter and are not counted. A closing flag after one or more counted bits gives a one-cycle `frame_end` in the cycle after the flag's last bit is taken. Back-to-back flags with no counted bits give no strobe.
- R3: Status bit 0 (short) is set when fewer than 32 bits were counted in 16-bit mode, or fewer than 48 bits in 32-bit mode.
- R4: Status bit 1 (check error) is set unless the check register holds the good residue: 0xF0B8 in 16-bit mode, 0xDEBB20E3 in 32-bit mode. The register is reflected, starts at all ones at each opening flag, and covers every counted bit. Bit 1 is don't-care when bit 2 or bit 3 is set.
- R5: Status bit 2 (non-octet) is set when the counted bit total is not a multiple of 8. It is don't-care when bit 3 is set.
- R6: Suppose the next counted bit would make the count exceed `max_len`. That bit is dropped, the frame ends with status bit 3 (long) set, and all input is ignored until the next flag. A count that is exactly `max_len` is not long.
- R7: Status bit 4 (abort) is set when a seventh consecutive 1 arrives inside a frame, or when `fast_abort` is high during a frame. Either event ends the frame and the block then waits for a flag. `fast_abort` outside a frame has no effect.
- R8: Status bit 5 (overflow) is set when `ovf_in` was high in any cycle of the frame, including the ending cycle.
- R9: `status` is all zero in every cycle in which `frame_end` is low.
- R10: After reset all outputs are zero. The receiver ignores all bits until the first flag.
- R11: Cycles with `bit_en` low have no effect on reception.
- R12: Inside a frame, a 0 that follows five consecutive 1s is removed before counting or checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit is valid this cycle |
| bit_in | input | 1 | Serial line bit |
| crc32_mode | input | 1 | 1 selects 32-bit check, 0 selects 16-bit check |
| max_len | input | LEN_W | Largest accepted count of frame bits |
| fast_abort | input | 1 | Ends the current frame as aborted |
| ovf_in | input | 1 | Downstream buffer lost data |
| byte_out | output | 8 | Received byte |
| byte_vld | output | 1 | `byte_out` is valid |
| frame_end | output | 1 | Frame-end strobe |
| status | output | 6 | Frame status, valid with `frame_end` |

## Verification
The bench builds the block with `LEN_W` = 10. This lets `max_len` be set to 64, so the long-frame cut and its exact boundary (64 bits accepted, 65 rejected) can be reached with frames of a few bytes. Payloads are chosen so that bit stuffing, the short-frame limit in both check widths, and non-octet lengths all appear within short runs. Frames are mixed with idle enable cycles that carry inverted bits, aborts, and fast-abort pulses both inside and outside a frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int          DLY       = 7;
    localparam int          FILL_W    = $clog2(DLY + 1);
    localparam int          RUN_W     = 3;
    localparam int          STUFF_RUN = 5;
    localparam int          FLAG_RUN  = 6;
    localparam int          SHORT16   = 32;
    localparam int          SHORT32   = 48;
    localparam logic [31:0] POLY16    = 32'h0000_8408;
    localparam logic [31:0] POLY32    = 32'hEDB8_8320;
    localparam logic [15:0] GOOD16    = 16'hF0B8;
    localparam logic [31:0] GOOD32    = 32'hDEBB_20E3;

    typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;

    typedef struct packed {
        logic ovf;
        logic abrt;
        logic lng;
        logic nonoct;
        logic crcerr;
        logic shrt;
    } rx_stat_t;

    typedef struct packed {
        logic flag;
        logic abrt;
        logic dvld;
        logic dbit;
    } line_ev_t;

    function automatic logic [31:0] crc_seed(logic wide);
        return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] crc_next(logic [31:0] c, logic b, logic wide);
        logic [31:0] n;
        n = wide ? {1'b0, c[31:1]} : {17'b0, c[15:1]};
        if (c[0] ^ b)
            n = n ^ (wide ? POLY32 : POLY16);
        return n;
    endfunction

endpackage

// File: rtl/hdlc_rx_linedec.sv
module hdlc_rx_linedec
    import hdlc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     bit_in,
    output line_ev_t ev
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] ones;

    always_comb begin
        ev      = '0;
        ev.dbit = bit_in;
        if (bit_en) begin
            if (!bit_in) begin
                if (ones == RUN_W'(FLAG_RUN))
                    ev.flag = 1'b1;
                else if (ones != RUN_W'(STUFF_RUN))
                    ev.dvld = 1'b1;
            end else begin
                if (ones == RUN_W'(FLAG_RUN))
                    ev.abrt = 1'b1;
                else if (ones < RUN_W'(FLAG_RUN))
                    ev.dvld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ones <= '0;
        else if (bit_en) begin
            if (!bit_in)
                ones <= '0;
            else if (ones != RUN_MAX)
                ones <= ones + RUN_W'(1);
        end
    end

endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic step,
    input  logic bit_i,
    input  logic wide,
    output logic ok
);
    logic [31:0] crc;

    always_ff @(posedge clk) begin
        if (rst)
            crc <= '0;
        else if (init)
            crc <= crc_seed(wide);
        else if (step)
            crc <= crc_next(crc, bit_i, wide);
    end

    assign ok = wide ? (crc == GOOD32) : (crc[15:0] == GOOD16);

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             crc32_mode,
    input  logic [LEN_W-1:0] max_len,
    input  logic             fast_abort,
    input  logic             ovf_in,
    output logic [7:0]       byte_out,
    output logic             byte_vld,
    output logic             frame_end,
    output logic [5:0]       status
);
    rx_state_e         state;
    line_ev_t          ev;
    logic [DLY-1:0]    dly;
    logic [FILL_W-1:0] fill;
    logic [LEN_W-1:0]  cnt;
    logic [7:0]        acc;
    logic              ovf_seen;
    logic              crc_ok;
    rx_stat_t          stat_q;
    rx_stat_t          stat_n;

    logic in_frame, push, full, commit, at_max, take;
    logic ev_fast, ev_abort, ev_close, ev_long, finish, start, ovf_now;

    hdlc_rx_linedec u_line (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .ev     (ev)
    );

    hdlc_rx_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (start),
        .step  (take),
        .bit_i (dly[0]),
        .wide  (crc32_mode),
        .ok    (crc_ok)
    );

    always_comb begin
        in_frame = (state == ST_FRAME);
        push     = in_frame && ev.dvld && !fast_abort;
        full     = (fill == FILL_W'(DLY));
        commit   = push && full;
        at_max   = (cnt == max_len);
        take     = commit && !at_max;
        ev_fast  = in_frame && fast_abort;
        ev_abort = in_frame && !fast_abort && ev.abrt;
        ev_close = in_frame && !fast_abort && ev.flag && (cnt != '0);
        ev_long  = commit && at_max;
        finish   = ev_fast || ev_abort || ev_close || ev_long;
        start    = ev.flag && !ev_fast;
        ovf_now  = ovf_seen || ovf_in;

        stat_n        = '0;
        stat_n.shrt   = int'(cnt) < (crc32_mode ? SHORT32 : SHORT16);
        stat_n.crcerr = !crc_ok;
        stat_n.nonoct = |cnt[2:0];
        stat_n.lng    = ev_long;
        stat_n.abrt   = ev_fast || ev_abort;
        stat_n.ovf    = ovf_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            dly       <= '0;
            fill      <= '0;
            cnt       <= '0;
            acc       <= '0;
            ovf_seen  <= 1'b0;
            stat_q    <= '0;
            frame_end <= 1'b0;
            byte_out  <= '0;
            byte_vld  <= 1'b0;
        end else begin
            frame_end <= finish;
            stat_q    <= finish ? stat_n : '0;
            byte_vld  <= 1'b0;
            if (start) begin
                state    <= ST_FRAME;
                fill     <= '0;
                cnt      <= '0;
                acc      <= '0;
                ovf_seen <= 1'b0;
            end else if (finish) begin
                state <= ST_HUNT;
            end else if (in_frame) begin
                ovf_seen <= ovf_now;
                if (push) begin
                    dly <= {ev.dbit, dly[DLY-1:1]};
                    if (!full)
                        fill <= fill + FILL_W'(1);
                end
                if (take) begin
                    acc <= {dly[0], acc[7:1]};
                    cnt <= cnt + LEN_W'(1);
                    if (cnt[2:0] == 3'd7) begin
                        byte_out <= {dly[0], acc[7:1]};
                        byte_vld <= 1'b1;
                    end
                end
            end
        end
    end

    assign status = stat_q;

    // R9: no status outside the strobe cycle
    a_r9_status_quiet: assert property (@(posedge clk) disable iff (rst)
        !frame_end |-> (status == 6'd0));

    // R7: a fast abort inside a frame ends it as aborted
    a_r7_fast_abort: assert property (@(posedge clk) disable iff (rst)
        (in_frame && fast_abort) |=> (frame_end && status[4]));

    // R6: a long frame leaves the receiver hunting for a flag
    a_r6_long_hunts: assert property (@(posedge clk) disable iff (rst)
        (frame_end && status[3]) |-> (state == ST_HUNT));

    // R10: no bytes are produced while hunting
    a_r10_hunt_no_bytes: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT) |=> !byte_vld);

    // R8: overflow reported on the ending cycle is carried into status
    a_r8_ovf_on_end: assert property (@(posedge clk) disable iff (rst)
        (in_frame && fast_abort && ovf_in) |=> status[5]);

endmodule

// File: tb/hdlc_rx_status_test.sv
module hdlc_rx_status_test;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bit_en = 1'b0;
    logic          bit_in = 1'b0;
    logic          crc32_mode = 1'b0;
    logic [LW-1:0] max_len = 10'd600;
    logic          fast_abort = 1'b0;
    logic          ovf_in = 1'b0;
    logic [7:0]    byte_out;
    logic          byte_vld;
    logic          frame_end;
    logic [5:0]    status;

    hdlc_rx_status #(.LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .crc32_mode(crc32_mode), .max_len(max_len), .fast_abort(fast_abort),
        .ovf_in(ovf_in), .byte_out(byte_out), .byte_vld(byte_vld),
        .frame_end(frame_end), .status(status)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int fe_cnt = 0;
    int byte_cnt = 0;
    logic [5:0] last_st = '0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic b, logic w);
        logic fb;
        fb = c[0] ^ b;
        if (w) begin
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end else begin
            c = {16'd0, 1'b0, c[15:1]};
            if (fb) c = c ^ 32'h00008408;
        end
        return c;
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_ones;
    bit          m_in;
    int          m_cnt;
    logic [31:0] m_crc;
    bit          m_ovf;
    bit          mq[$];
    logic [7:0]  m_acc;
    bit          armed = 0;
    bit          e_fe, e_bv;
    logic [5:0]  e_st;
    logic [7:0]  e_by;
    bit          d_flag, d_ab, d_dv, d_b, ov_now, cb;

    task automatic m_end(bit lng, bit ab, bit ovn);
        e_fe = 1;
        e_st[0] = m_cnt < (crc32_mode ? 48 : 32);
        e_st[1] = crc32_mode ? (m_crc != 32'hDEBB20E3) : (m_crc[15:0] != 16'hF0B8);
        e_st[2] = (m_cnt % 8) != 0;
        e_st[3] = lng;
        e_st[4] = ab;
        e_st[5] = ovn;
        m_in = 0;
    endtask

    task automatic m_start();
        m_in = 1;
        m_cnt = 0;
        mq.delete();
        m_crc = crc32_mode ? 32'hFFFFFFFF : 32'h0000FFFF;
        m_ovf = 0;
        m_acc = 0;
    endtask

    always @(posedge clk) begin
        e_fe = 0;
        e_bv = 0;
        e_st = '0;
        if (rst) begin
            m_ones = 0;
            m_in = 0;
            armed = 1;
        end else begin
            d_flag = 0; d_ab = 0; d_dv = 0; d_b = bit_in;
            if (bit_en) begin
                if (!bit_in) begin
                    if (m_ones == 6) d_flag = 1;
                    else if (m_ones != 5) d_dv = 1;
                    m_ones = 0;
                end else begin
                    if (m_ones == 6) d_ab = 1;
                    else if (m_ones < 6) d_dv = 1;
                    if (m_ones < 7) m_ones++;
                end
            end
            ov_now = m_ovf | ovf_in;
            if (m_in) begin
                if (fast_abort) m_end(0, 1, ov_now);
                else if (d_ab) m_end(0, 1, ov_now);
                else if (d_flag) begin
                    if (m_cnt > 0) m_end(0, 0, ov_now);
                    m_start();
                end else begin
                    m_ovf = ov_now;
                    if (d_dv) begin
                        mq.push_back(d_b);
                        if (mq.size() > 7) begin
                            cb = mq.pop_front();
                            if (m_cnt == int'(max_len)) m_end(1, 0, ov_now);
                            else begin
                                m_crc = ref_crc(m_crc, cb, crc32_mode);
                                m_acc = {cb, m_acc[7:1]};
                                m_cnt++;
                                if (m_cnt % 8 == 0) begin
                                    e_bv = 1;
                                    e_by = m_acc;
                                end
                            end
                        end
                    end
                end
            end else if (d_flag) m_start();
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (armed) begin
            chk(frame_end == e_fe, "R2 frame_end strobe", frame_end, e_fe);
            chk(byte_vld == e_bv, "R1 byte_vld", byte_vld, e_bv);
            if (e_bv && byte_vld) chk(byte_out == e_by, "R1 R12 byte value", byte_out, e_by);
            if (e_fe && frame_end) begin
                chk(status[0] == e_st[0], "R3 short bit", status[0], e_st[0]);
                chk(status[3] == e_st[3], "R6 long bit", status[3], e_st[3]);
                chk(status[4] == e_st[4], "R7 abort bit", status[4], e_st[4]);
                chk(status[5] == e_st[5], "R8 overflow bit", status[5], e_st[5]);
                if (!e_st[3])
                    chk(status[2] == e_st[2], "R5 non-octet bit", status[2], e_st[2]);
                if (!e_st[3] && !e_st[2])
                    chk(status[1] == e_st[1], "R4 check bit", status[1], e_st[1]);
            end else if (!frame_end) begin
                chk(status == 6'd0, "R9 status quiet", status, 0);
            end
            if (frame_end) begin
                fe_cnt++;
                last_st = status;
            end
            if (byte_vld) byte_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    bit          raw[$];
    int          st_ones;
    logic [7:0]  pl[$];
    logic [31:0] gen_crc;
    int          put_idx = 0;

    task automatic add_flag();
        raw.push_back(0);
        for (int i = 0; i < 6; i++) raw.push_back(1);
        raw.push_back(0);
        st_ones = 0;
    endtask

    task automatic add_st(bit b);
        raw.push_back(b);
        if (b) begin
            st_ones++;
            if (st_ones == 5) begin
                raw.push_back(0);
                st_ones = 0;
            end
        end else st_ones = 0;
    endtask

    task automatic add_body(int lo, int hi, bit corrupt);
        bit b;
        if (lo == 0) gen_crc = crc32_mode ? 32'hFFFFFFFF : 32'h0000FFFF;
        for (int i = lo; i < hi; i++) begin
            b = pl[i / 8][i % 8];
            gen_crc = ref_crc(gen_crc, b, crc32_mode);
            if (corrupt && i == 0) b = ~b;
            add_st(b);
        end
    endtask

    task automatic add_fcs();
        logic [31:0] f;
        f = ~gen_crc;
        for (int i = 0; i < (crc32_mode ? 32 : 16); i++) add_st(f[i]);
    endtask

    task automatic put(bit b);
        @(negedge clk);
        bit_en = 1;
        bit_in = b;
        put_idx++;
        if (put_idx % 4 == 0) begin
            @(negedge clk);
            bit_en = 0;
            bit_in = ~b;
        end
    endtask

    task automatic play();
        foreach (raw[i]) put(raw[i]);
        raw.delete();
        @(negedge clk);
        bit_en = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic clr();
        fe_cnt = 0;
        byte_cnt = 0;
    endtask

    task automatic pulse_fast();
        @(negedge clk);
        bit_en = 0;
        fast_abort = 1;
        @(negedge clk);
        fast_abort = 0;
    endtask

    task automatic pulse_ovf();
        @(negedge clk);
        bit_en = 0;
        ovf_in = 1;
        @(negedge clk);
        ovf_in = 0;
    endtask

    task automatic expect_end(logic [5:0] care, logic [5:0] val, string tag);
        chk(fe_cnt == 1, {tag, " strobe count"}, fe_cnt, 1);
        chk((last_st & care) == val, {tag, " status"}, last_st & care, val);
        clr();
    endtask

    task automatic expect_none(string tag);
        chk(fe_cnt == 0, tag, fe_cnt, 0);
        clr();
    endtask

    task automatic good_frame(int nbits);
        add_flag();
        add_body(0, nbits, 0);
        add_fcs();
        add_flag();
        play();
        settle();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({byte_vld, frame_end, status, byte_out} == '0, "R10 reset outputs",
            {byte_vld, frame_end, status, byte_out}, 0);
        rst = 0;
        clr();

        // R10: bits before any flag, including a long run of ones, are ignored
        raw = '{1,0,1,1,0,0,1,0,1,1,1,1,1,1,1,0,1,0,0,1,1};
        play();
        settle();
        expect_none("R10 hunting ignores data");
        chk(byte_cnt == 0, "R10 no bytes before flag", byte_cnt, 0);

        // R1 R4 R12 R11: good 16-bit frame with stuffing-heavy payload
        pl = '{8'h12, 8'hFF, 8'h7E, 8'h3F, 8'hA5, 8'h00};
        clr();
        good_frame(48);
        expect_end(6'h3F, 6'h00, "R1 R4 R11 R12 good frame");

        // R2: back-to-back flags give no strobe
        add_flag(); add_flag(); add_flag();
        play();
        settle();
        expect_none("R2 back-to-back flags");

        // R4: check error
        add_flag(); add_body(0, 48, 1); add_fcs(); add_flag();
        play(); settle();
        expect_end(6'h0E, 6'h02, "R4 corrupted frame");

        // R3: short frame in 16-bit mode and its boundary
        good_frame(8);
        expect_end(6'h3F, 6'h01, "R3 short 24 bits");
        good_frame(16);
        expect_end(6'h3F, 6'h00, "R3 exactly 32 bits");

        // R5: non-octet frame
        good_frame(35);
        expect_end(6'h0D, 6'h04, "R5 non-octet 51 bits");

        // R6: length limit boundary and overrun
        max_len = 10'd64;
        pl = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF, 8'h55, 8'hAA};
        good_frame(48);
        expect_end(6'h3F, 6'h00, "R6 exactly max_len");
        good_frame(80);
        chk(byte_cnt == 8, "R6 bytes stop at limit", byte_cnt, 8);
        expect_end(6'h39, 6'h08, "R6 long frame");
        max_len = 10'd600;

        // R7: abort sequence ends the frame
        add_flag(); add_body(0, 24, 0);
        for (int i = 0; i < 10; i++) raw.push_back(1);
        play(); settle();
        expect_end(6'h18, 6'h10, "R7 abort sequence");

        // R7: fast abort while hunting has no effect
        pulse_fast();
        settle();
        expect_none("R7 fast abort outside frame");

        // R7: fast abort inside a frame
        add_flag(); add_body(0, 32, 0);
        play();
        pulse_fast();
        add_body(32, 48, 0); add_fcs(); add_flag();
        play(); settle();
        expect_end(6'h18, 6'h10, "R7 fast abort");
        add_flag(); play(); settle();
        expect_none("R2 flag after abort opens frame");

        // R8: overflow during a frame
        add_flag(); add_body(0, 16, 0);
        play();
        pulse_ovf();
        add_body(16, 48, 0); add_fcs(); add_flag();
        play(); settle();
        expect_end(6'h3F, 6'h20, "R8 overflow");

        // 32-bit mode: good, short, boundary
        crc32_mode = 1;
        good_frame(24);
        expect_end(6'h3F, 6'h00, "R4 good 32-bit frame");
        good_frame(8);
        expect_end(6'h3F, 6'h01, "R3 short 40 bits in 32-bit mode");
        good_frame(16);
        expect_end(6'h3F, 6'h00, "R3 exactly 48 bits in 32-bit mode");

        summary();
        $finish;
    end

endmodule